// File: doc/BRIEF.md
# Indexed Codec Control Register Interface

This block is the byte-wide host-facing register interface of an audio codec. The host sees four direct ports selected by a 2-bit address: an index pointer, a data window, a status byte and a programmed-I/O data byte. Thirty-two indirect control registers sit behind the data window. The index pointer selects which one a data-port access reaches. The contents of all indirect registers are exported in parallel to the rest of the codec.

The block applies the codec's access rules:
- Writes to the sample-format register are gated by two mode-change enables.
- Some locations are read-only or reserved.
- The width of the index decode follows a mode bit.
- The interrupt status is cleared through the status port or through the alternate status register.

The playback engine raises interrupts through a single-cycle request input. After the host enters mode-change with calibration bits configured, a short calibration-busy indication is returned for a counted number of reads.

Top module: `codec_regif`

## Requirements
- R1: After reset the index port reads 0x40, registers 2 to 5 and 18 to 19 hold 0x88, registers 6 and 7 hold 0x80, register 9 holds 0x08, register 12 holds 0x8A, registers 25 and 26 hold 0xA0, every other indirect register holds 0, and the IRQ is low.
- R2: Port address 0 is the index pointer. Its bit 7 is dropped on write and reads back as 0; bit 6 is the mode-change enable (MCE) and bits 6:0 read back as written.
- R3: Port address 1 accesses indirect register number equal to the low 4 bits of the index pointer. When register 12 bit 6 (extended mode) is 1, the low 5 bits are used instead. Reads of port 1 are combinational on the current state.
- R4: A write to register 8 is taken whole when MCE is 1. When MCE is 0 and register 24 bit 4 is 1, only bits 7:4 change. Otherwise the write is dropped.
- R5: Register 9 bit 5 is forced to 0 on write. Register 11 is read-only. Writes to registers 22, 27 and 29 are dropped. In register 12 only bit 6 is writable.
- R6: Any write to port 2 clears status bit 0, clears register 24 bits 6:4 and drives the IRQ low in the next cycle.
- R7: A write to register 24 that takes bit 4 from 1 to 0 also clears status bit 0 and the IRQ.
- R8: An interrupt request (irq_set) sets status bit 0, the IRQ and register 24 bit 4. A port-2 write or a register-24 bit-4 clear in the same cycle wins over the request. A register-24 write in the same cycle replaces the whole register.
- R9: A 0-to-1 change of MCE written while register 9 bits 4:3 are nonzero loads a calibration count of CAL_READS. While the count is nonzero, each port-1 read of register 11 returns bit 5 set and lowers the count by one.
- R10: Port 3 reads 0x00 and writes to it change nothing. Port 2 reads 0x00 except bit 0, which is the interrupt status.
- R11: regs_out carries indirect register n on bits 8n+7 down to 8n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Direct port select |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, qualifies side effects of reads |
| wdata | input | 8 | Write data |
| irq_set | input | 1 | Interrupt request from the playback engine |
| rdata | output | 8 | Read data for the addressed port |
| irq | output | 1 | Interrupt line |
| regs_out | output | 256 | Flattened indirect register contents |

## Verification
The hardest state to reach is the calibration-busy window. It needs the index pointer to have MCE clear, register 9 bits 4:3 set, and then an index write that both raises MCE and points at register 11. Only then do the next two data-port reads tell a loaded counter from an unloaded one. The stimulus first drops MCE with a plain index write, then does a raising write, then reads twice. It repeats this with register 9 bits 4:3 cleared to show no load happens. The same-cycle contests between irq_set and the clearing writes are also forced directly, and the format-register gating is checked with extended mode turned on so that register 24 can be reached.

// File: rtl/codec_regif_pkg.sv
package codec_regif_pkg;
  localparam int NREG    = 32;
  localparam int DW      = 8;
  localparam int IDXW    = 5;
  localparam int R_FMT   = 8;
  localparam int R_IFC   = 9;
  localparam int R_CAL   = 11;
  localparam int R_MODE  = 12;
  localparam int R_ALTS  = 24;
  localparam logic [6:0] IDX_RST = 7'h40;

  function automatic logic [DW-1:0] reg_rst(input int n);
    case (n)
      2, 3, 4, 5, 18, 19: reg_rst = 8'h88;
      6, 7:               reg_rst = 8'h80;
      9:                  reg_rst = 8'h08;
      12:                 reg_rst = 8'h8A;
      25, 26:             reg_rst = 8'hA0;
      default:            reg_rst = 8'h00;
    endcase
  endfunction

  function automatic logic is_dropped(input int n);
    is_dropped = (n == R_CAL) || (n == 22) || (n == 27) || (n == 29);
  endfunction
endpackage

// File: rtl/codec_idx_port.sv
module codec_idx_port
  import codec_regif_pkg::*;
#(
  parameter int CAL_READS = 1,
  localparam int CW = $clog2(CAL_READS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic [1:0] cal_cfg,
  input  logic       cal_rd,
  output logic [6:0] idx_q,
  output logic       cal_busy
);
  logic [6:0]    idx_d;
  logic          idx_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          cal_load;

  always_comb begin
    idx_en   = idx_wr;
    idx_d    = wdata[6:0];
    cal_load = idx_wr && !idx_q[6] && wdata[6] && (cal_cfg != 2'b00);
    cnt_en   = 1'b0;
    cnt_d    = cnt_q;
    if (cal_load) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(CAL_READS);
    end else if (cal_rd && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= IDX_RST;
      cnt_q <= '0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cal_busy = (cnt_q != '0);

  // R9: entering mode change with calibration configured makes the busy flag visible
  assert_cal_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !idx_q[6] && wdata[6] && (cal_cfg != 2'b00)) |=> cal_busy);

  // R9: the last counted read ends the busy window
  assert_cal_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_rd && !idx_wr && (cnt_q == CW'(1))) |=> !cal_busy);

  // R2: an index write is reflected in the next cycle
  assert_idx_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(wdata[6:0])));
endmodule

// File: rtl/codec_ind_regfile.sv
module codec_ind_regfile
  import codec_regif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dat_wr,
  input  logic [IDXW-1:0]      idx,
  input  logic [7:0]           wdata,
  input  logic                 mce,
  input  logic                 irq_set,
  input  logic                 sts_wr,
  output logic [NREG*DW-1:0]   regs_o,
  output logic                 pi_clr
);
  logic [7:0] alts_cur;
  assign alts_cur = regs_o[R_ALTS*DW +: DW];

  assign pi_clr = dat_wr && (idx == IDXW'(R_ALTS)) && alts_cur[4] && !wdata[4];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int N = g;
    logic [7:0] q, d;
    logic       en;
    logic       hit;

    assign hit = dat_wr && (idx == IDXW'(N));

    always_comb begin
      en = 1'b0;
      d  = q;
      if (N == R_ALTS) begin
        if (hit) begin
          en = 1'b1;
          d  = wdata;
        end else if (sts_wr) begin
          en = 1'b1;
          d  = q & 8'h8F;
        end else if (irq_set) begin
          en = 1'b1;
          d  = q | 8'h10;
        end
      end else if (hit) begin
        if (N == R_FMT) begin
          if (mce) begin
            en = 1'b1;
            d  = wdata;
          end else if (alts_cur[4]) begin
            en = 1'b1;
            d  = {wdata[7:4], q[3:0]};
          end
        end else if (N == R_IFC) begin
          en = 1'b1;
          d  = wdata & 8'hDF;
        end else if (N == R_MODE) begin
          en = 1'b1;
          d  = {q[7], wdata[6], q[5:0]};
        end else if (!is_dropped(N)) begin
          en = 1'b1;
          d  = wdata;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= reg_rst(N);
      else if (en) q <= d;
    end

    assign regs_o[N*DW +: DW] = q;
  end

  logic [7:0] fmt_cur;
  assign fmt_cur = regs_o[R_FMT*DW +: DW];

  // R4: neither enable set, the format register does not move
  assert_fmt_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (idx == IDXW'(R_FMT)) && !mce && !alts_cur[4]) |=> $stable(fmt_cur));

  // R4: partial enable keeps the low nibble
  assert_fmt_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (idx == IDXW'(R_FMT)) && !mce) |=> (fmt_cur[3:0] == $past(fmt_cur[3:0])));

  // R6: a status-port write clears the three pending bits of register 24
  assert_alts_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> (alts_cur[6:4] == 3'b000));

  // R5: register 11 never changes
  assert_ro_cal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && (idx == IDXW'(R_CAL))) |=> $stable(regs_o[R_CAL*DW +: DW]));
endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sts_wr,
  input  logic pi_clr,
  input  logic irq_set,
  output logic int_q
);
  logic int_d, int_en;

  always_comb begin
    int_en = 1'b0;
    int_d  = int_q;
    if (sts_wr || pi_clr) begin
      int_en = 1'b1;
      int_d  = 1'b0;
    end else if (irq_set) begin
      int_en = 1'b1;
      int_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      int_q <= 1'b0;
    else if (int_en) int_q <= int_d;
  end

  // R6: status write drops the interrupt
  assert_sts_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> !int_q);

  // R7: clearing the pending bit in register 24 drops the interrupt
  assert_pi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pi_clr |=> !int_q);

  // R8: an uncontested request raises the interrupt
  assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set && !sts_wr && !pi_clr) |=> int_q);
endmodule

// File: rtl/codec_regif.sv
module codec_regif
  import codec_regif_pkg::*;
#(
  parameter int CAL_READS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          addr,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [7:0]          wdata,
  input  logic                irq_set,
  output logic [7:0]          rdata,
  output logic                irq,
  output logic [NREG*DW-1:0]  regs_out
);
  logic [6:0]      idx_q;
  logic            cal_busy;
  logic [IDXW-1:0] idx;
  logic            xmode;
  logic            int_q;
  logic            pi_clr;
  logic            idx_wr, dat_wr, sts_wr;
  logic [7:0]      sel_reg;

  assign xmode  = regs_out[R_MODE*DW + 6];
  assign idx    = xmode ? idx_q[4:0] : {1'b0, idx_q[3:0]};
  assign idx_wr = wr_en && (addr == 2'd0);
  assign dat_wr = wr_en && (addr == 2'd1);
  assign sts_wr = wr_en && (addr == 2'd2);

  codec_idx_port #(.CAL_READS(CAL_READS)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (wdata),
    .cal_cfg  (regs_out[R_IFC*DW + 3 +: 2]),
    .cal_rd   (rd_en && (addr == 2'd1) && (idx == IDXW'(R_CAL))),
    .idx_q    (idx_q),
    .cal_busy (cal_busy)
  );

  codec_ind_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .dat_wr  (dat_wr),
    .idx     (idx),
    .wdata   (wdata),
    .mce     (idx_q[6]),
    .irq_set (irq_set),
    .sts_wr  (sts_wr),
    .regs_o  (regs_out),
    .pi_clr  (pi_clr)
  );

  codec_irq_ctrl u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .sts_wr  (sts_wr),
    .pi_clr  (pi_clr),
    .irq_set (irq_set),
    .int_q   (int_q)
  );

  assign sel_reg = regs_out[{idx, 3'b000} +: DW];

  always_comb begin
    case (addr)
      2'd0:    rdata = {1'b0, idx_q};
      2'd1:    rdata = sel_reg | ((idx == IDXW'(R_CAL)) && cal_busy ? 8'h20 : 8'h00);
      2'd2:    rdata = {7'b0, int_q};
      default: rdata = 8'h00;
    endcase
  end

  assign irq = int_q;

  // R10: writes to the PIO port leave the register file untouched
  assert_pio_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == 2'd3) && !irq_set) |=> $stable(regs_out));

  // R8: the IRQ line follows the interrupt status bit seen on port 2
  always_comb begin
    if (rst_n && (addr == 2'd2)) assert_irq_status_R8: assert (rdata[0] == irq);
  end
endmodule

// File: tb/codec_regif_test.sv
module codec_regif_test;
  localparam int CLK_NS = 20;
  localparam int CAL    = 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   addr;
  logic         wr_en, rd_en, irq_set;
  logic [7:0]   wdata;
  logic [7:0]   rdata;
  logic         irq;
  logic [255:0] regs_out;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  int m_reg [32];
  int m_idx;
  int m_int;
  int m_cal;

  always #(CLK_NS/2) clk = ~clk;

  codec_regif #(.CAL_READS(CAL)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .irq_set(irq_set), .rdata(rdata), .irq(irq), .regs_out(regs_out)
  );

  function automatic int m_sel();
    return ((m_reg[12] & 64) != 0) ? (m_idx & 31) : (m_idx & 15);
  endfunction

  function automatic int m_rd(input int a);
    int v;
    case (a)
      0: v = m_idx;
      1: begin
        v = m_reg[m_sel()];
        if (m_sel() == 11 && m_cal > 0) v = v | 32;
      end
      2: v = m_int;
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_reg[i] = 0;
    for (int i = 2; i <= 5; i++) m_reg[i] = 'h88;
    m_reg[18] = 'h88; m_reg[19] = 'h88;
    m_reg[6] = 'h80;  m_reg[7] = 'h80;
    m_reg[9] = 'h08;  m_reg[12] = 'h8A;
    m_reg[25] = 'hA0; m_reg[26] = 'hA0;
    m_idx = 'h40; m_int = 0; m_cal = 0;
  endtask

  task automatic model_clk(input int a, input bit w, input bit r, input int d, input bit s);
    int  n;
    bit  pi_clr;
    bit  wr24;
    bit  stsw;
    n = m_sel();
    pi_clr = 0; wr24 = 0; stsw = 0;
    if (r && a == 1 && n == 11 && m_cal > 0) m_cal--;
    if (w) begin
      case (a)
        0: begin
          if ((m_idx & 64) == 0 && (d & 64) != 0 && ((m_reg[9] >> 3) & 3) != 0) m_cal = CAL;
          m_idx = d & 127;
        end
        1: begin
          if (n == 8) begin
            if ((m_idx & 64) != 0) m_reg[8] = d;
            else if ((m_reg[24] & 16) != 0) m_reg[8] = (d & 'hF0) | (m_reg[8] & 'h0F);
          end else if (n == 9) m_reg[9] = d & 'hDF;
          else if (n == 11 || n == 22 || n == 27 || n == 29) begin end
          else if (n == 12) m_reg[12] = (m_reg[12] & 'hBF) | (d & 'h40);
          else if (n == 24) begin
            wr24 = 1;
            if ((m_reg[24] & 16) != 0 && (d & 16) == 0) pi_clr = 1;
            m_reg[24] = d;
          end else m_reg[n] = d;
        end
        2: stsw = 1;
        default: begin end
      endcase
    end
    if (!wr24) begin
      if (stsw) m_reg[24] = m_reg[24] & 'h8F;
      else if (s) m_reg[24] = m_reg[24] | 'h10;
    end
    if (stsw || pi_clr) m_int = 0;
    else if (s) m_int = 1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare_model();
    check("R10 model rdata", int'(rdata), m_rd(int'(addr)));
    check("R8 model irq", int'(irq), m_int);
    for (int i = 0; i < 32; i++)
      check($sformatf("R11 model reg%0d", i), int'(regs_out[i*8 +: 8]), m_reg[i]);
  endtask

  task automatic step(input int a, input bit w, input bit r, input int d, input bit s,
                      input bit chk, input int exp, input string tag);
    addr = 2'(a); wr_en = w; rd_en = r; wdata = 8'(d); irq_set = s;
    #1;
    compare_model();
    if (chk) check(tag, int'(rdata), exp);
    @(posedge clk);
    model_clk(a, w, r, d, s);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    step(a, 1, 0, d, 0, 0, 0, "");
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    step(a, 0, 1, 0, 0, 1, exp, tag);
  endtask

  task automatic chk_reg(input int n, input int exp, input string tag);
    check(tag, int'(regs_out[n*8 +: 8]), exp);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    addr = 0; wr_en = 0; rd_en = 0; wdata = 0; irq_set = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rd(0, 'h40, "R1 index reset");
    chk_reg(2, 'h88, "R1 reg2 reset");
    chk_reg(12, 'h8A, "R1 reg12 reset");
    chk_reg(25, 'hA0, "R1 reg25 reset");
    chk_reg(9, 'h08, "R1 reg9 reset");
    check("R1 irq reset", int'(irq), 0);
    chk_reg(19, 'h88, "R11 regs_out reg19");

    // index port bit 7
    wr(0, 'hFF);
    rd(0, 'h7F, "R2 bit7 dropped");

    // format register gating
    wr(0, 'h48); wr(1, 'h5A);
    rd(1, 'h5A, "R4 full write with MCE");
    wr(0, 'h08); wr(1, 'hC3);
    rd(1, 'h5A, "R4 write dropped");
    wr(0, 'h0C); wr(1, 'hFF);
    rd(1, 'hCA, "R5 reg12 only bit6");
    wr(0, 'h18); wr(1, 'h10);
    check("R7 no irq from write", int'(irq), 0);
    wr(0, 'h08); wr(1, 'hC3);
    rd(1, 'hCA, "R4 upper nibble only");

    // protected locations
    wr(0, 'h09); wr(1, 'hFF);
    rd(1, 'hDF, "R5 reg9 bit5 forced");
    wr(0, 'h0B); wr(1, 'h55);
    rd(1, 'h00, "R5 reg11 read-only");
    wr(0, 'h16); wr(1, 'h77);
    rd(1, 'h00, "R5 reg22 dropped");
    wr(0, 'h1B); wr(1, 'h77);
    rd(1, 'h00, "R5 reg27 dropped");
    wr(0, 'h1D); wr(1, 'h77);
    rd(1, 'h00, "R5 reg29 dropped");

    // index width
    wr(0, 'h19);
    rd(1, 'hA0, "R3 five-bit index");
    wr(0, 'h0C); wr(1, 'h00);
    wr(0, 'h19);
    rd(1, 'hDF, "R3 four-bit index");

    // interrupts
    wr(2, 'h00);
    check("R6 irq low", int'(irq), 0);
    chk_reg(24, 'h00, "R6 reg24 cleared");
    step(3, 0, 0, 0, 1, 0, 0, "");
    check("R8 irq raised", int'(irq), 1);
    chk_reg(24, 'h10, "R8 reg24 bit4");
    rd(2, 'h01, "R10 status shows INT");
    step(2, 1, 0, 0, 1, 0, 0, "");
    check("R8 clear beats set", int'(irq), 0);
    chk_reg(24, 'h00, "R8 reg24 after contest");
    step(3, 0, 0, 0, 1, 0, 0, "");
    wr(0, 'h0C); wr(1, 'h40);
    wr(0, 'h18); wr(1, 'h20);
    check("R7 pi clear drops irq", int'(irq), 0);
    chk_reg(24, 'h20, "R7 reg24 written");

    // calibration window
    wr(0, 'h09); wr(1, 'h18);
    wr(0, 'h4B);
    rd(1, 'h20, "R9 busy on first read");
    rd(1, 'h00, "R9 busy gone");
    wr(0, 'h09); wr(1, 'h07);
    wr(0, 'h0B); wr(0, 'h4B);
    rd(1, 'h00, "R9 no load with cfg zero");

    // PIO port
    wr(3, 'hAA);
    rd(3, 'h00, "R10 pio reads zero");
    rd(2, 'h00, "R10 status clear");

    repeat (2) step(0, 0, 0, 0, 0, 0, 0, "");
    done = 1;
    finish_run();
  end
endmodule